// File: doc/BRIEF.md
# Configuration frame address sequencer

This block steps through every configuration frame address of a column-based programmable fabric. Each address has five fields: a frame type, a top/bottom half flag, a region index, a major number that selects a column, and a minor number that selects a frame inside that column. The sequence is built from a column-type table given as a parameter, which lists the physical columns from left to right. The block also reports how many frames the current column holds.

A start pulse loads the first address. Each advance strobe then moves to the next address. After the final address, the valid flag drops and a one-cycle done pulse follows. In the main area, BRAM columns get no major number. Instead they are numbered in two separate areas, one for BRAM contents and one for BRAM routing. The global clock spine has no table entry of its own. It receives its own major number, placed directly after the center column.

Top module: `cfg_frame_addr_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `addr_valid` and `done` are both low.
- R2: A `start` pulse makes `addr_valid` high one cycle later, with the address type 0, top half (`half_bottom`=0), region 0, major 0 and minor 0. `start` wins over `advance` and restarts the sequence at any point.
- R3: Addresses follow this order: minor changes fastest, then major, then region (0 up to REGIONS_PER_HALF-1, counted outward from the configuration tile), then half (top, then bottom), then frame type (0, 1, 2).
- R4: Table entry i sits in `COL_TABLE[3i+2:3i]`, and entry 0 is the leftmost column. The codes are CLB=0, DSP=1, IO=2, center=3, MGT=4, BRAM=5. In type 0, every non-BRAM column gets a major number counted from 0 on the left. The spine slot takes the major number right after the center column.
- R5: In type 0, `col_frames` is 22 for CLB, 21 for DSP, 30 for IO or center, 20 for MGT and 3 for the spine. Minor runs from 0 to `col_frames`-1.
- R6: Type 1 visits only BRAM columns, with majors counted from 0 on the left and 64 frames each.
- R7: Type 2 visits only BRAM columns, with majors counted from 0 on the left and 20 frames each.
- R8: An advance on the final address drops `addr_valid` on the next cycle and raises `done` for exactly one cycle.
- R9: `advance` while `addr_valid` is low (including while `done` is high) has no effect. The block stays idle until the next `start`.
- R10: While `advance` and `start` are low, the address and `col_frames` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin or restart the sequence |
| advance | input | 1 | Step to the next address |
| addr_valid | output | 1 | The address outputs are meaningful |
| frame_type | output | 2 | 0 main, 1 BRAM contents, 2 BRAM routing |
| half_bottom | output | 1 | 0 top half, 1 bottom half |
| region | output | RW | Region index within the half |
| major | output | MW | Column number within the frame type |
| minor | output | 6 | Frame number within the column |
| col_frames | output | 7 | Frame count of the current column |
| done | output | 1 | One-cycle pulse after the final address |

## Verification
The assertions expect `start` and `advance` to be synchronous single-bit controls. They also expect the column table to hold valid codes and at least one center column. Under those conditions every visited column has a nonzero frame count, so the minor field is always below `col_frames`. The stimulus uses only the default table and drives each control at the falling edge. It covers random gaps in `advance`, a restart in mid-sequence with `advance` held high, `advance` while idle and during `done`, and a full run without gaps.

// File: rtl/cfa_pkg.sv
package cfa_pkg;

  typedef enum logic [2:0] {
    COL_CLB    = 3'd0,
    COL_DSP    = 3'd1,
    COL_IO     = 3'd2,
    COL_CENTER = 3'd3,
    COL_MGT    = 3'd4,
    COL_BRAM   = 3'd5,
    COL_SPINE  = 3'd6
  } col_kind_e;

  localparam int MAX_COLS = 64;
  localparam int MINOR_W  = 6;
  localparam int FRAMES_W = 7;

  typedef logic [3*MAX_COLS-1:0] col_tbl_t;

  // frame count of one column for a given frame type
  function automatic logic [FRAMES_W-1:0] kind_frames(input logic [1:0] ftype,
                                                      input logic [2:0] kind);
    logic [FRAMES_W-1:0] n;
    if (ftype == 2'd1)      n = 7'd64;
    else if (ftype == 2'd2) n = 7'd20;
    else begin
      case (kind)
        COL_CLB:               n = 7'd22;
        COL_DSP:               n = 7'd21;
        COL_IO, COL_CENTER:    n = 7'd30;
        COL_MGT:               n = 7'd20;
        COL_SPINE:             n = 7'd3;
        default:               n = 7'd0;
      endcase
    end
    return n;
  endfunction

  // number of majors in the main area (non-BRAM columns plus the spine)
  function automatic int count_main(input col_tbl_t tbl, input int n);
    int c;
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (tbl[3*i +: 3] != COL_BRAM)   c++;
      if (tbl[3*i +: 3] == COL_CENTER) c++;
    end
    return c;
  endfunction

  function automatic int count_bram(input col_tbl_t tbl, input int n);
    int c;
    c = 0;
    for (int i = 0; i < n; i++)
      if (tbl[3*i +: 3] == COL_BRAM) c++;
    return c;
  endfunction

  // column kind held by main-area slot m
  function automatic logic [2:0] main_slot(input col_tbl_t tbl, input int n, input int m);
    int s;
    logic [2:0] res;
    s   = 0;
    res = COL_CLB;
    for (int i = 0; i < n; i++) begin
      if (tbl[3*i +: 3] != COL_BRAM) begin
        if (s == m) res = tbl[3*i +: 3];
        s++;
      end
      if (tbl[3*i +: 3] == COL_CENTER) begin
        if (s == m) res = COL_SPINE;
        s++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/cfa_col_map.sv
module cfa_col_map
  import cfa_pkg::*;
#(
  parameter int NUM_COLS = 10,
  parameter logic [3*NUM_COLS-1:0] COL_TABLE = '0,
  parameter int MW = 4
) (
  input  logic [1:0]          ftype,
  input  logic [MW-1:0]       major,
  output logic [2:0]          kind,
  output logic [FRAMES_W-1:0] nframes
);

  localparam int SLOTS = NUM_COLS + 1;
  localparam col_tbl_t TBL = col_tbl_t'(COL_TABLE);

  logic [2:0] slot_kind [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_kind[g] = main_slot(TBL, NUM_COLS, g);
  end

  always_comb begin
    if (ftype != 2'd0)             kind = COL_BRAM;
    else if (int'(major) < SLOTS)  kind = slot_kind[major];
    else                           kind = COL_CLB;
    nframes = kind_frames(ftype, kind);
  end

endmodule

// File: rtl/cfa_step.sv
module cfa_step
  import cfa_pkg::*;
#(
  parameter int REGIONS     = 2,
  parameter int RW          = 1,
  parameter int MW          = 4,
  parameter int MAIN_MAJORS = 9,
  parameter int BRAM_MAJORS = 2
) (
  input  logic [1:0]          cur_type,
  input  logic                cur_half,
  input  logic [RW-1:0]       cur_region,
  input  logic [MW-1:0]       cur_major,
  input  logic [MINOR_W-1:0]  cur_minor,
  input  logic [FRAMES_W-1:0] cur_frames,
  output logic [1:0]          nxt_type,
  output logic                nxt_half,
  output logic [RW-1:0]       nxt_region,
  output logic [MW-1:0]       nxt_major,
  output logic [MINOR_W-1:0]  nxt_minor,
  output logic                is_last
);

  logic last_minor, last_major, last_region, last_type;
  int   majors_here;

  always_comb begin
    majors_here = (cur_type == 2'd0) ? MAIN_MAJORS : BRAM_MAJORS;
    last_minor  = ({1'b0, cur_minor} == cur_frames - 7'd1);
    last_major  = (int'(cur_major) == majors_here - 1);
    last_region = (int'(cur_region) == REGIONS - 1);
    last_type   = (cur_type == 2'd2) || (BRAM_MAJORS == 0);
    is_last     = last_minor && last_major && last_region && cur_half && last_type;

    nxt_type   = cur_type;
    nxt_half   = cur_half;
    nxt_region = cur_region;
    nxt_major  = cur_major;
    nxt_minor  = cur_minor + 1'b1;
    if (last_minor) begin
      nxt_minor = '0;
      nxt_major = cur_major + 1'b1;
      if (last_major) begin
        nxt_major  = '0;
        nxt_region = cur_region + 1'b1;
        if (last_region) begin
          nxt_region = '0;
          nxt_half   = 1'b1;
          if (cur_half) begin
            nxt_half = 1'b0;
            nxt_type = cur_type + 2'd1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/cfg_frame_addr_seq.sv
module cfg_frame_addr_seq
  import cfa_pkg::*;
#(
  parameter int NUM_COLS = 10,
  parameter int REGIONS_PER_HALF = 2,
  parameter logic [3*NUM_COLS-1:0] COL_TABLE =
    {3'd4, 3'd2, 3'd5, 3'd0, 3'd3, 3'd1, 3'd5, 3'd0, 3'd2, 3'd4},
  localparam int RW = (REGIONS_PER_HALF > 1) ? $clog2(REGIONS_PER_HALF) : 1,
  localparam int MW = $clog2(NUM_COLS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                advance,
  output logic                addr_valid,
  output logic [1:0]          frame_type,
  output logic                half_bottom,
  output logic [RW-1:0]       region,
  output logic [MW-1:0]       major,
  output logic [MINOR_W-1:0]  minor,
  output logic [FRAMES_W-1:0] col_frames,
  output logic                done
);

  localparam col_tbl_t TBL = col_tbl_t'(COL_TABLE);
  localparam int MAIN_MAJORS = count_main(TBL, NUM_COLS);
  localparam int BRAM_MAJORS = count_bram(TBL, NUM_COLS);

  logic [2:0]         cur_kind;
  logic [1:0]         nxt_type;
  logic               nxt_half;
  logic [RW-1:0]      nxt_region;
  logic [MW-1:0]      nxt_major;
  logic [MINOR_W-1:0] nxt_minor;
  logic               is_last;

  cfa_col_map #(
    .NUM_COLS (NUM_COLS),
    .COL_TABLE(COL_TABLE),
    .MW       (MW)
  ) u_map (
    .ftype  (frame_type),
    .major  (major),
    .kind   (cur_kind),
    .nframes(col_frames)
  );

  cfa_step #(
    .REGIONS    (REGIONS_PER_HALF),
    .RW         (RW),
    .MW         (MW),
    .MAIN_MAJORS(MAIN_MAJORS),
    .BRAM_MAJORS(BRAM_MAJORS)
  ) u_step (
    .cur_type  (frame_type),
    .cur_half  (half_bottom),
    .cur_region(region),
    .cur_major (major),
    .cur_minor (minor),
    .cur_frames(col_frames),
    .nxt_type  (nxt_type),
    .nxt_half  (nxt_half),
    .nxt_region(nxt_region),
    .nxt_major (nxt_major),
    .nxt_minor (nxt_minor),
    .is_last   (is_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid  <= 1'b0;
      done        <= 1'b0;
      frame_type  <= '0;
      half_bottom <= 1'b0;
      region      <= '0;
      major       <= '0;
      minor       <= '0;
    end else if (start) begin
      addr_valid  <= 1'b1;
      done        <= 1'b0;
      frame_type  <= '0;
      half_bottom <= 1'b0;
      region      <= '0;
      major       <= '0;
      minor       <= '0;
    end else if (addr_valid && advance) begin
      if (is_last) begin
        addr_valid <= 1'b0;
        done       <= 1'b1;
      end else begin
        frame_type  <= nxt_type;
        half_bottom <= nxt_half;
        region      <= nxt_region;
        major       <= nxt_major;
        minor       <= nxt_minor;
      end
    end else begin
      done <= 1'b0;
    end
  end

  // R2: start loads the first address
  a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
    start |=> addr_valid && frame_type == 2'd0 && !half_bottom &&
              region == '0 && major == '0 && minor == '0);

  // R8: done is a single-cycle pulse and never overlaps a valid address
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !addr_valid);

  // R5: the minor field stays inside the current column
  a_r5_minor_range: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> ({1'b0, minor} < col_frames));

  // R3: inside a column only the minor field moves
  a_r3_minor_step: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && advance && !start && ({1'b0, minor} != col_frames - 7'd1))
    |=> (minor == $past(minor) + 1'b1) && $stable(major) && $stable(region) &&
        $stable(half_bottom) && $stable(frame_type));

  // R9: idle stays idle until start
  a_r9_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (!addr_valid && !start) |=> !addr_valid);

  // R10: no strobe, no movement
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !advance && !start) |=> addr_valid && $stable(minor) &&
      $stable(major) && $stable(region) && $stable(half_bottom) && $stable(frame_type));

endmodule

// File: tb/tb_cfg_frame_addr_seq.sv
module tb_cfg_frame_addr_seq;

  localparam int NCOLS = 10;
  localparam int NREG  = 2;
  localparam logic [3*NCOLS-1:0] TABLE =
    {3'd4, 3'd2, 3'd5, 3'd0, 3'd3, 3'd1, 3'd5, 3'd0, 3'd2, 3'd4};

  logic       clk = 1'b0;
  logic       rst, start, advance;
  logic       addr_valid, half_bottom, done;
  logic [1:0] frame_type;
  logic [0:0] region;
  logic [3:0] major;
  logic [5:0] minor;
  logic [6:0] col_frames;

  cfg_frame_addr_seq #(.NUM_COLS(NCOLS), .REGIONS_PER_HALF(NREG), .COL_TABLE(TABLE)) dut (
    .clk(clk), .rst(rst), .start(start), .advance(advance),
    .addr_valid(addr_valid), .frame_type(frame_type), .half_bottom(half_bottom),
    .region(region), .major(major), .minor(minor), .col_frames(col_frames), .done(done)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  typedef struct { int t; int h; int r; int mj; int mn; int fr; } ent_t;
  ent_t exp_q[$];

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int ptr   = 0;
  bit mvalid = 0;
  bit mdone  = 0;

  function automatic int frames_of(int code);
    case (code)
      0: return 22;
      1: return 21;
      2, 3: return 30;
      4: return 20;
      default: return 3;  // spine
    endcase
  endfunction

  task automatic push_col(int t, int h, int r, int mj, int fr);
    for (int k = 0; k < fr; k++) begin
      ent_t e;
      e.t = t; e.h = h; e.r = r; e.mj = mj; e.mn = k; e.fr = fr;
      exp_q.push_back(e);
    end
  endtask

  task automatic build_list();
    for (int t = 0; t < 3; t++)
      for (int h = 0; h < 2; h++)
        for (int r = 0; r < NREG; r++) begin
          int mj = 0;
          for (int i = 0; i < NCOLS; i++) begin
            int code = int'(TABLE[3*i +: 3]);
            if (t == 0) begin
              if (code != 5) begin push_col(t, h, r, mj, frames_of(code)); mj++; end
              if (code == 3) begin push_col(t, h, r, mj, 3); mj++; end
            end else if (code == 5) begin
              push_col(t, h, r, mj, (t == 1) ? 64 : 20);
              mj++;
            end
          end
        end
  endtask

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // reference model, updated on the same edge as the design
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      mvalid <= 0; mdone <= 0;
    end else if (start) begin
      ptr <= 0; mvalid <= 1; mdone <= 0;
    end else if (mvalid && advance) begin
      if (ptr == exp_q.size() - 1) begin mvalid <= 0; mdone <= 1; end
      else ptr <= ptr + 1;
    end else begin
      mdone <= 0;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(addr_valid == mvalid, "R9", "addr_valid", int'(addr_valid), int'(mvalid));
      chk(done == mdone, "R8", "done", int'(done), int'(mdone));
      if (mvalid) begin
        ent_t e;
        string rq;
        string rf;
        e  = exp_q[ptr];
        rq = (e.t == 0) ? "R4" : (e.t == 1) ? "R6" : "R7";
        rf = (e.t == 0) ? "R5" : (e.t == 1) ? "R6" : "R7";
        chk(int'(frame_type) == e.t, "R3", "frame_type", int'(frame_type), e.t);
        chk(int'(half_bottom) == e.h, "R3", "half_bottom", int'(half_bottom), e.h);
        chk(int'(region) == e.r, "R3", "region", int'(region), e.r);
        chk(int'(major) == e.mj, rq, "major", int'(major), e.mj);
        chk(int'(minor) == e.mn, rf, "minor", int'(minor), e.mn);
        chk(int'(col_frames) == e.fr, rf, "col_frames", int'(col_frames), e.fr);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; advance = 1'b0;
    build_list();
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk(!addr_valid, "R1", "valid in reset", int'(addr_valid), 0);
    chk(!done, "R1", "done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!addr_valid && !done, "R1", "idle after reset", int'(addr_valid | done), 0);

    // R9: advance while idle does nothing
    advance = 1'b1;
    repeat (4) @(negedge clk);
    chk(!addr_valid, "R9", "valid after idle advance", int'(addr_valid), 0);

    // R2: start loads the first address
    advance = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(addr_valid && frame_type == 0 && !half_bottom && region == 0 && major == 0 && minor == 0,
        "R2", "first address", int'(minor), 0);
    chk(col_frames == 7'd20, "R2", "first column frames", int'(col_frames), 20);

    // R10: no strobe holds the address
    advance = 1'b1;
    repeat (25) @(negedge clk);
    advance = 1'b0;
    begin
      logic [5:0] mn0;
      logic [3:0] mj0;
      mn0 = minor; mj0 = major;
      repeat (3) @(negedge clk);
      chk(minor == mn0 && major == mj0, "R10", "hold minor", int'(minor), int'(mn0));
    end

    // random gaps in advance
    for (int i = 0; i < 300; i++) begin
      advance = ($urandom % 4) != 0;
      @(negedge clk);
    end

    // R2: restart mid-sequence, start beating advance
    advance = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(major == 0 && minor == 0 && frame_type == 0, "R2", "restart minor", int'(minor), 0);

    // run to the end, then advance during done and idle
    while (!done) @(negedge clk);
    chk(!addr_valid, "R8", "valid at done", int'(addr_valid), 0);
    @(negedge clk);
    chk(!done, "R8", "done one cycle", int'(done), 0);
    repeat (4) @(negedge clk);
    chk(!addr_valid, "R9", "advance after done", int'(addr_valid), 0);

    // full gap-free run: count addresses visited
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int seen = 0;
      while (!done) begin
        if (addr_valid) seen++;
        @(negedge clk);
      end
      chk(seen == exp_q.size(), "R3", "address count", seen, exp_q.size());
    end
    advance = 1'b0;
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule